// File: doc/BRIEF.md
# General Status and Control Register Bank

This block is the small register bank that a chip's host processor uses for housekeeping. Software reaches it over a simple synchronous register bus. It holds a general control register, a register that drives a set of external status pins, and a fixed identity and revision code. It also provides two views of internal status. The live view always shows the present state of its inputs. The latched view catches short events and keeps them until software has read them.

Bit 0 of the general control register starts a software master reset. The block then drives an internal reset pulse of a fixed length to the rest of the chip and returns its own registers to their defaults. The bit clears itself when the pulse ends. Bit 2 of the same register is the pin mode bit, which decides whether the output-status register reaches the pins.

Bus protocol: `bus_wr` or `bus_rd` is high for one cycle, with `bus_addr` valid in that cycle. A write takes effect at that clock edge. Read data is registered.

Top module: `stat_ctrl_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank goes to its defaults: control register 0x00, output-status register 0, latched bits 0, `soft_rst_o` low, `stat_pins_o` 0 and `bus_rdata` 0.
- R2: Address 0x0 is the control register. Bits 7..1 can be written and read back. `ctrl_o` always shows the whole register, and bit 0 reads as the master reset state.
- R3: A write to 0x0 with bit 0 set raises `soft_rst_o` from the next cycle for exactly RST_CYCLES cycles (4 by default). During the pulse, `ctrl_o` reads 0x01, and the other bits written with bit 0 are dropped. When the pulse ends, bit 0 clears itself, and the control register, the output-status register and all latched bits are at their defaults.
- R4: While `soft_rst_o` is high, bus writes have no effect and `event_in` does not set latched bits.
- R5: Address 0x2 holds the output-status register. Its low OUT_W bits (4 by default) can be written and read back, and the upper bits read as 0.
- R6: `stat_pins_o` equals the output-status register while control bit 2 is 1. It is 0 while that bit is 0.
- R7: Address 0x3 always reads VERSION (0x21 by default). Writes to it have no effect.
- R8: A read of address 0x4 returns `event`-independent live status: the value of `live_in` in the read cycle, zero-extended.
- R9: A latched bit at address 0x5 becomes 1 after any clock edge at which its `event_in` bit is high. It stays 1 until 0x5 is read.
- R10: A read of 0x5 returns the latched bits and then clears them. If an event arrives in the same cycle as the read, its bit is set again, so the next read returns it.
- R11: `bus_rdata` changes only in the cycle after a `bus_rd` cycle and holds its value otherwise. Addresses 0x1 and 0x6..0xF read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| live_in | input | STAT_W (8) | Raw live status conditions |
| event_in | input | STAT_W (8) | Transient event conditions to be latched |
| ctrl_o | output | DATA_W (8) | Control register contents |
| stat_pins_o | output | OUT_W (4) | External status pins |
| soft_rst_o | output | 1 | Internal master reset pulse |

## Verification
The assertions check several rules on every cycle:
- the status pins stay at 0 while the pin mode bit is clear;
- each reset pulse lasts exactly RST_CYCLES cycles, and the bank is at its defaults when the pulse ends;
- read data holds between reads;
- the identity and live reads return the expected values.

Some behaviour only the bench scenarios can show. This covers the round trip of the writable fields and the clear-on-read of latched bits, including an event that arrives in the same cycle as the read. It also covers writes and events that are blocked during the pulse, and silent unmapped addresses.

// File: rtl/scr_pkg.sv
// Package: shared widths and register addresses of the status/control bank.
// Assumes a 4-bit word address space with byte-wide registers.
package scr_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    // Register addresses. The control, pin-level and identity offsets are fixed
    // because other software decodes them.
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_PINS   = 4'h2;
    localparam logic [ADDR_W-1:0] A_ID     = 4'h3;
    localparam logic [ADDR_W-1:0] A_LIVE   = 4'h4;
    localparam logic [ADDR_W-1:0] A_STICKY = 4'h5;

    // Bit positions inside the control register.
    localparam int B_SOFTRST = 0;
    localparam int B_PINMODE = 2;
endpackage

// File: rtl/scr_reset_seq.sv
// Module: soft reset sequencer.
// A start request produces an active pulse of exactly RST_CYCLES clocks.
// Assumes RST_CYCLES >= 1. Requests that arrive while the pulse runs are ignored.
module scr_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Load the counter on start, count it down, and drop active after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
        end else if (!active && start) begin
            active <= 1'b1;
            remain <= CNT_INIT;
        end else if (active) begin
            if (remain == '0) begin
                active <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/scr_sticky_bits.sv
// Module: latched (sticky) status bits.
// Each bit sets on a high event and holds until rd_clr. An event in the
// clearing cycle wins, so no event is lost. clr_all forces every bit to 0.
module scr_sticky_bits #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         rd_clr,
    input  logic [W-1:0] ev,
    output logic [W-1:0] bits
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One sticky flop per status bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                bits[i] <= 1'b0;
            end else begin
                bits[i] <= (bits[i] & ~rd_clr) | ev[i];
            end
        end
    end
endmodule

// File: rtl/scr_read_mux.sv
// Module: read data selector for the register bank.
// Purely combinational. Unmapped addresses return zero.
// Assumes STAT_W and OUT_W do not exceed the data width.
module scr_read_mux
    import scr_pkg::*;
#(
    parameter int STAT_W = 8,
    parameter int OUT_W  = 4,
    parameter logic [DATA_W-1:0] VERSION = 8'h21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [OUT_W-1:0]  pins,
    input  logic [STAT_W-1:0] live,
    input  logic [STAT_W-1:0] sticky,
    output logic [DATA_W-1:0] data
);
    // Select the addressed register, zero-extending the narrow ones.
    always_comb begin
        data = '0;
        unique case (addr)
            A_CTRL:   data = ctrl;
            A_PINS:   data[OUT_W-1:0] = pins;
            A_ID:     data = VERSION;
            A_LIVE:   data[STAT_W-1:0] = live;
            A_STICKY: data[STAT_W-1:0] = sticky;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/stat_ctrl_bank.sv
// Module: general status and control register bank (top).
// Holds the control register, output-status pin register, identity code,
// live status and latched status, all on a one-cycle strobe register bus.
// Assumes a synchronous active-low rst_n. While the soft reset runs, all of
// this bank's registers are held at their defaults.
module stat_ctrl_bank
    import scr_pkg::*;
#(
    parameter int STAT_W     = 8,
    parameter int OUT_W      = 4,
    parameter int RST_CYCLES = 4,
    parameter logic [DATA_W-1:0] VERSION = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] live_in,
    input  logic [STAT_W-1:0] event_in,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [OUT_W-1:0]  stat_pins_o,
    output logic              soft_rst_o
);
    logic                soft_active;
    logic                wr_en;
    logic                soft_start;
    logic                clr_regs;
    logic                sticky_rd;
    logic [DATA_W-1:1]   ctrl_hi;
    logic [OUT_W-1:0]    pin_reg;
    logic [STAT_W-1:0]   sticky;
    logic [DATA_W-1:0]   ctrl_full;
    logic [DATA_W-1:0]   rd_mux;

    // Bus writes are blocked while the soft reset pulse runs.
    assign wr_en      = bus_wr && !soft_active;
    assign soft_start = wr_en && (bus_addr == A_CTRL) && bus_wdata[B_SOFTRST];
    assign clr_regs   = soft_start || soft_active;
    assign sticky_rd  = bus_rd && (bus_addr == A_STICKY);
    assign ctrl_full  = {ctrl_hi, soft_active};

    scr_reset_seq #(.RST_CYCLES(RST_CYCLES)) rst_seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (soft_start),
        .active (soft_active)
    );

    // Writable control bits. A soft reset returns them to their defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_regs) begin
            ctrl_hi <= '0;
        end else if (wr_en && bus_addr == A_CTRL) begin
            ctrl_hi <= bus_wdata[DATA_W-1:1];
        end
    end

    // Output-status pin level register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_regs) begin
            pin_reg <= '0;
        end else if (wr_en && bus_addr == A_PINS) begin
            pin_reg <= bus_wdata[OUT_W-1:0];
        end
    end

    scr_sticky_bits #(.W(STAT_W)) sticky_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_regs),
        .rd_clr  (sticky_rd),
        .ev      (event_in),
        .bits    (sticky)
    );

    scr_read_mux #(.STAT_W(STAT_W), .OUT_W(OUT_W), .VERSION(VERSION)) rd_mux_i (
        .addr   (bus_addr),
        .ctrl   (ctrl_full),
        .pins   (pin_reg),
        .live   (live_in),
        .sticky (sticky),
        .data   (rd_mux)
    );

    // Registered read data. It updates only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign ctrl_o      = ctrl_full;
    assign soft_rst_o  = soft_active;
    assign stat_pins_o = ctrl_hi[B_PINMODE] ? pin_reg : '0;
endmodule

// File: rtl/scr_bank_chk.sv
// Module: assertion checker for stat_ctrl_bank, attached with bind.
// Observes ports only. It counts the length of the reset pulse itself.
module scr_bank_chk
    import scr_pkg::*;
#(
    parameter int STAT_W     = 8,
    parameter int OUT_W      = 4,
    parameter int RST_CYCLES = 4,
    parameter logic [DATA_W-1:0] VERSION = 8'h21
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [STAT_W-1:0] live_in,
    input logic [DATA_W-1:0] ctrl_o,
    input logic [OUT_W-1:0]  stat_pins_o,
    input logic              soft_rst_o
);
    int unsigned          hi_cnt;
    logic [DATA_W-1:0]    live_ext;

    // Count how many consecutive earlier cycles had the reset pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= 0;
        else if (soft_rst_o) hi_cnt <= hi_cnt + 1;
        else hi_cnt <= 0;
    end

    // Zero-extend live status to the bus width.
    always_comb begin
        live_ext = '0;
        live_ext[STAT_W-1:0] = live_in;
    end

    AST_PINS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[B_PINMODE] |-> stat_pins_o == '0); // R6
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> hi_cnt < RST_CYCLES); // R3
    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_o) |-> hi_cnt == RST_CYCLES); // R3
    AST_PULSE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_o) |-> (ctrl_o == '0 && stat_pins_o == '0)); // R3
    AST_PULSE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> ctrl_o == DATA_W'(1)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R11
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == A_ID) |-> bus_rdata == VERSION); // R7
    AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == A_LIVE) |-> bus_rdata == $past(live_ext)); // R8
endmodule

bind stat_ctrl_bank scr_bank_chk #(
    .STAT_W(STAT_W), .OUT_W(OUT_W), .RST_CYCLES(RST_CYCLES), .VERSION(VERSION)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .live_in    (live_in),
    .ctrl_o     (ctrl_o),
    .stat_pins_o(stat_pins_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/stat_ctrl_bank_tb_top.sv
// Bench for stat_ctrl_bank: a vector table of bus operations, then directed tests.
module stat_ctrl_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] live_in = '0;
    logic [7:0] event_in = '0;
    logic [7:0] ctrl_o;
    logic [3:0] stat_pins_o;
    logic       soft_rst_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    stat_ctrl_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_in(live_in), .event_in(event_in), .ctrl_o(ctrl_o),
        .stat_pins_o(stat_pins_o), .soft_rst_o(soft_rst_o)
    );

    typedef struct packed {
        logic       is_rd;
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 8'h04, 4'd2},   // R2 enable pin mode
        '{1'b1, 4'h0, 8'h04, 4'd2},
        '{1'b0, 4'h2, 8'h0A, 4'd5},   // R5
        '{1'b1, 4'h2, 8'h0A, 4'd5},
        '{1'b0, 4'h2, 8'hFA, 4'd5},   // R5 upper bits dropped
        '{1'b1, 4'h2, 8'h0A, 4'd5},
        '{1'b1, 4'h3, 8'h21, 4'd7},   // R7
        '{1'b0, 4'h3, 8'hFF, 4'd7},
        '{1'b1, 4'h3, 8'h21, 4'd7},
        '{1'b1, 4'h1, 8'h00, 4'd11},  // R11 unmapped
        '{1'b0, 4'h1, 8'h55, 4'd11},
        '{1'b1, 4'h1, 8'h00, 4'd11},
        '{1'b1, 4'h9, 8'h00, 4'd11},
        '{1'b0, 4'h0, 8'hF6, 4'd2},   // R2
        '{1'b1, 4'h0, 8'hF6, 4'd2},
        '{1'b0, 4'h0, 8'h04, 4'd2},
        '{1'b1, 4'h5, 8'h00, 4'd9}    // R9 nothing latched yet
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", ctrl_o, 8'h00);
        check("R1 pins", {4'h0, stat_pins_o}, 8'h00);
        check("R1 soft", {7'h0, soft_rst_o}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d table %0d", VECS[i].req, i), rd, VECS[i].data);
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R6 pin gating (pin mode on, levels 0xA)
        check("R6 pins on", {4'h0, stat_pins_o}, 8'h0A);
        bus_write(4'h0, 8'h00);
        check("R6 pins off", {4'h0, stat_pins_o}, 8'h00);
        bus_write(4'h0, 8'h04);
        check("R6 pins back", {4'h0, stat_pins_o}, 8'h0A);
        check("R2 ctrl_o", ctrl_o, 8'h04);

        // R8 live status
        live_in = 8'h3C;
        bus_read(4'h4, rd);
        check("R8 live a", rd, 8'h3C);
        live_in = 8'hC3;
        bus_read(4'h4, rd);
        check("R8 live b", rd, 8'hC3);

        // R11 hold between reads
        live_in = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 8'hC3);

        // R9 a one-cycle event is latched
        @(negedge clk); event_in = 8'h01;
        @(negedge clk); event_in = 8'h00;
        repeat (3) @(negedge clk);
        // R10 read with an event in the same cycle
        @(negedge clk);
        bus_addr = 4'h5; bus_rd = 1'b1; event_in = 8'h80;
        @(negedge clk);
        bus_rd = 1'b0; event_in = 8'h00;
        check("R9 latched", bus_rdata, 8'h01);
        bus_read(4'h5, rd);
        check("R10 same-cycle event kept", rd, 8'h80);
        bus_read(4'h5, rd);
        check("R10 cleared", rd, 8'h00);

        // R3 soft reset pulse length and defaults
        bus_write(4'h2, 8'h0F);
        bus_write(4'h0, 8'hF6);
        @(negedge clk); event_in = 8'h10;
        @(negedge clk); event_in = 8'h00;
        bus_write(4'h0, 8'hF3);
        check("R3 ctrl during pulse", ctrl_o, 8'h01);
        hi = 0;
        for (int k = 0; k < 8; k++) begin
            if (soft_rst_o) hi++;
            @(negedge clk);
        end
        check("R3 pulse length", 8'(hi), 8'd4);
        check("R3 ctrl default", ctrl_o, 8'h00);
        check("R3 pins default", {4'h0, stat_pins_o}, 8'h00);
        bus_read(4'h2, rd);
        check("R3 pin reg default", rd, 8'h00);
        bus_read(4'h5, rd);
        check("R3 latched default", rd, 8'h00);

        // R4 writes and events are ignored during the pulse
        bus_write(4'h0, 8'h01);
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'h07; bus_wr = 1'b1; event_in = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0; event_in = 8'h00;
        bus_write(4'h0, 8'h04);
        repeat (6) @(negedge clk);
        bus_read(4'h2, rd);
        check("R4 write blocked", rd, 8'h00);
        bus_read(4'h5, rd);
        check("R4 event blocked", rd, 8'h00);
        bus_read(4'h0, rd);
        check("R4 ctrl write blocked", rd, 8'h00);

        summary();
        $finish;
    end
endmodule